// File: doc/BRIEF.md
# Open-Row SDRAM Line-Burst Controller

This controller connects a 32-bit processor bus to one SDRAM bank group, and both sides share one clock. It serves cache-line transfers of four consecutive long-words. It also serves single byte, word and long-word accesses for traffic that cannot use a burst. It keeps one row open between requests. A request whose row matches the open row skips the precharge and activate steps. The delay to the first beat depends on two things: the direction of the transfer, and whether the request hits the open row.

The bus starts a transaction with a one-cycle start strobe. With the strobe it gives a burst flag, a direction flag, a 2-bit size code and an address. The controller returns one acknowledge pulse per beat. A periodic refresh runs only between transactions. It closes every row, so the access that follows always opens its row again.

Top module: `sdram_line_ctrl`

## Requirements
- R1: A write that hits the open row asserts its first `xfer_ack` in cycle 3, where the cycle in which `xfer_start` is sampled counts as cycle 1. No activate command is issued for it.
- R2: A read that hits the open row asserts its first `xfer_ack` in cycle 5. Every read beat is preceded, one cycle earlier, by a READ command (ras_n, cas_n, we_n = 1,0,1).
- R3: A write that misses asserts its first `xfer_ack` in cycle 7. It issues a precharge (0,1,0) and then, two cycles later, an activate (0,1,1).
- R4: A read that misses asserts its first `xfer_ack` in cycle 9.
- R5: A burst (`burst`=1) gives exactly four `xfer_ack` pulses in consecutive cycles. A single transfer gives exactly one. No precharge or activate command is issued during an acknowledged beat.
- R6: Burst beats visit long-word columns starting at the requested one. The low two column bits count up modulo 4, so the beats stay inside the aligned 16-byte line. The column is `addr[9:2]` and the row is `addr[21:10]`. Read data is `sd_dq_i` during the acknowledged cycle. Write data `wdata` appears on `sd_dq_o` with `sd_dq_oe`=1 and a WRITE command (1,0,0) only during acknowledged cycles.
- R7: During a beat, `sd_dqm` is low for the enabled byte lanes. Lane 3 is bits 31:24. Size code 00 (long) and all bursts enable every lane. Code 01 (byte) enables lane 3-`addr[1:0]`. Code 10 (word) enables lanes 3,2 when `addr[1]`=0 and lanes 1,0 otherwise.
- R8: A hit requires a valid open row equal to the request's row. Reset leaves no row open, so the first access is a miss. During reset `xfer_ack`=0, the command is NOP (1,1,1) and `sd_dq_oe`=0.
- R9: Every `REF_PERIOD` cycles a refresh becomes pending. It starts only when the controller is idle and no strobe is present. It issues a precharge-all (`sd_addr[10]`=1) and in the next cycle an auto-refresh (0,0,1). It then closes the open row, so the next access is a miss.
- R10: A start strobe that arrives while a transaction is in progress is ignored and causes no extra acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle transaction start strobe |
| burst | input | 1 | 1 = four-beat line transfer |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| size | input | 2 | Single-transfer size: 00 long, 01 byte, 10 word |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data for the current beat |
| rdata | output | 32 | Read data, valid while `xfer_ack` is high |
| xfer_ack | output | 1 | One pulse per completed beat |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_addr | output | ROW_W | Row, column or precharge-all address |
| sd_dqm | output | 4 | Per-lane data mask, high = masked |
| sd_dq_o | output | 32 | Data driven to the SDRAM |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_o` |
| sd_dq_i | input | 32 | Data returned by the SDRAM |

## Verification
Each acknowledge is due at a fixed cycle: 3, 5, 7 or 9 counted from the strobe cycle, followed by one beat per cycle. The bench samples on falling edges and numbers every cycle from the strobe onward, so it compares the exact cycle of the first acknowledge, not just whether one occurs. Read data comes from a responder that registers a pattern built from the row and column one cycle after each READ command. The bench checks that pattern during the acknowledged cycle. Refresh is checked by waiting for the auto-refresh command and then requiring the next access to have miss latency.

// File: rtl/sdl_pkg.sv
// Shared types for the line-burst SDRAM controller.
// Assumes a single bank group and big-endian lane numbering (lane 3 = bits 31:24).
package sdl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_REF
    } sdl_state_e;

    // Command encoding {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP   = 3'b111,
        CMD_ACT   = 3'b011,
        CMD_READ  = 3'b101,
        CMD_WRITE = 3'b100,
        CMD_PRE   = 3'b010,
        CMD_AREF  = 3'b001
    } sdl_cmd_e;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/sdl_lane_mask.sv
// Byte-lane enable generator.
// Derives the enabled lanes of a 32-bit beat from the size code and the low address bits.
// Assumes accesses are naturally aligned; bursts always use all lanes.
module sdl_lane_mask
    import sdl_pkg::*;
(
    input  logic       burst,
    input  logic [1:0] size,
    input  logic [1:0] low,
    output logic [3:0] lane_en
);
    // Select lanes for the request
    always_comb begin
        lane_en = 4'b1111;
        if (!burst) begin
            case (size)
                SZ_BYTE: lane_en = 4'b1000 >> low;
                SZ_WORD: lane_en = low[1] ? 4'b0011 : 4'b1100;
                default: lane_en = 4'b1111;
            endcase
        end
    end
endmodule

// File: rtl/sdl_row_tracker.sv
// Open-row register with valid bit.
// Reports whether a probed row is currently open; opens on activate, closes on refresh.
module sdl_row_tracker #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row,
    input  logic             close_all,
    input  logic [ROW_W-1:0] probe_row,
    output logic             hit
);
    logic             row_valid;
    logic [ROW_W-1:0] row_q;

    // Track the single open row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid <= 1'b0;
            row_q     <= '0;
        end else if (close_all) begin
            row_valid <= 1'b0;
        end else if (open_en) begin
            row_valid <= 1'b1;
            row_q     <= open_row;
        end
    end

    // Hit needs a valid row equal to the probe
    assign hit = row_valid && (row_q == probe_row);
endmodule

// File: rtl/sdl_refresh_timer.sv
// Periodic refresh request.
// Raises pending every PERIOD cycles and holds it until acknowledged.
module sdl_refresh_timer #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = $clog2(PERIOD);
    logic [CNT_W-1:0] cnt;

    // Free-running interval counter and sticky request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (cnt == CNT_W'(PERIOD - 1)) cnt <= '0;
            else                           cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(PERIOD - 1)) pending <= 1'b1;
            else if (ack)                  pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_line_ctrl.sv
// Open-row SDRAM line-burst controller (top).
// Serves 4-beat line bursts and single transfers with fixed first-beat latencies
// chosen by direction and row hit/miss, then one beat per cycle.
// Assumes the bus issues xfer_start only when idle, ROW_W > 10 and COL_W >= 2.
module sdram_line_ctrl
    import sdl_pkg::*;
#(
    parameter int ROW_W       = 12,
    parameter int COL_W       = 8,
    parameter int LAT_WR_HIT  = 3,
    parameter int LAT_RD_HIT  = 5,
    parameter int LAT_WR_MISS = 7,
    parameter int LAT_RD_MISS = 9,
    parameter int REF_PERIOD  = 780,
    parameter int REF_CYC     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             burst,
    input  logic             rd_nwr,
    input  logic [1:0]       size,
    input  logic [31:0]      addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             xfer_ack,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [ROW_W-1:0] sd_addr,
    output logic [3:0]       sd_dqm,
    output logic [31:0]      sd_dq_o,
    output logic             sd_dq_oe,
    input  logic [31:0]      sd_dq_i
);
    localparam int PH_W   = $clog2(LAT_RD_MISS + REF_CYC + 1);
    localparam int AP_BIT = 10;
    localparam int ROW_LO = 2 + COL_W;
    localparam logic [PH_W-1:0] PH_PRE = PH_W'(0);
    localparam logic [PH_W-1:0] PH_ACT = PH_W'(2);

    sdl_state_e       state;
    sdl_cmd_e         cmd;
    logic [PH_W-1:0]  ph, req_wlen, wlen_sel;
    logic [1:0]       beat, last_beat;
    logic             req_rd, req_burst, req_miss;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [3:0]       req_en, lane_en;
    logic             hit, ref_pending, ref_ack;

    sdl_lane_mask u_mask (
        .burst  (burst),
        .size   (size),
        .low    (addr[1:0]),
        .lane_en(lane_en)
    );

    sdl_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (state == ST_WAIT && req_miss && ph == PH_ACT),
        .open_row (req_row),
        .close_all(state == ST_REF && ph == PH_PRE),
        .probe_row(addr[ROW_LO +: ROW_W]),
        .hit      (hit)
    );

    sdl_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ref_ack),
        .pending(ref_pending)
    );

    // Refresh may start only in idle with no competing strobe
    assign ref_ack = (state == ST_IDLE) && !xfer_start && ref_pending;

    // Pick the wait length (first-beat latency minus strobe and first wait cycle)
    always_comb begin
        if (hit) wlen_sel = rd_nwr ? PH_W'(LAT_RD_HIT - 2)  : PH_W'(LAT_WR_HIT - 2);
        else     wlen_sel = rd_nwr ? PH_W'(LAT_RD_MISS - 2) : PH_W'(LAT_WR_MISS - 2);
    end

    assign last_beat = req_burst ? 2'd3 : 2'd0;

    // Transaction sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ph        <= '0;
            beat      <= '0;
            req_rd    <= 1'b0;
            req_burst <= 1'b0;
            req_miss  <= 1'b0;
            req_row   <= '0;
            req_col   <= '0;
            req_en    <= '0;
            req_wlen  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (xfer_start) begin
                        req_rd    <= rd_nwr;
                        req_burst <= burst;
                        req_miss  <= !hit;
                        req_row   <= addr[ROW_LO +: ROW_W];
                        req_col   <= addr[2 +: COL_W];
                        req_en    <= lane_en;
                        req_wlen  <= wlen_sel;
                        ph        <= '0;
                        state     <= ST_WAIT;
                    end else if (ref_pending) begin
                        ph    <= '0;
                        state <= ST_REF;
                    end
                end
                ST_WAIT: begin
                    ph <= ph + 1'b1;
                    if (ph == req_wlen - 1'b1) begin
                        beat  <= '0;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (beat == last_beat) state <= ST_IDLE;
                    else                   beat  <= beat + 1'b1;
                end
                ST_REF: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_W'(REF_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command and address generation from the sequencer state
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        unique case (state)
            ST_WAIT: begin
                if (req_miss && ph == PH_PRE) begin
                    cmd     = CMD_PRE;
                    sd_addr = ROW_W'(1) << AP_BIT;
                end else if (req_miss && ph == PH_ACT) begin
                    cmd     = CMD_ACT;
                    sd_addr = req_row;
                end else if (req_rd && ph == req_wlen - 1'b1) begin
                    cmd     = CMD_READ;
                    sd_addr = ROW_W'(req_col);
                end
            end
            ST_XFER: begin
                if (!req_rd) begin
                    cmd     = CMD_WRITE;
                    sd_addr = ROW_W'({req_col[COL_W-1:2], req_col[1:0] + beat});
                end else if (beat != last_beat) begin
                    cmd     = CMD_READ;
                    sd_addr = ROW_W'({req_col[COL_W-1:2], req_col[1:0] + beat + 2'd1});
                end
            end
            ST_REF: begin
                if (ph == PH_PRE) begin
                    cmd     = CMD_PRE;
                    sd_addr = ROW_W'(1) << AP_BIT;
                end else if (ph == PH_W'(1)) begin
                    cmd = CMD_AREF;
                end
            end
            default: ;
        endcase
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign xfer_ack = (state == ST_XFER);
    assign rdata    = sd_dq_i;
    assign sd_dq_o  = wdata;
    assign sd_dq_oe = (state == ST_XFER) && !req_rd;
    assign sd_dqm   = (state == ST_XFER) ? ~req_en : 4'hF;
endmodule

// File: rtl/sdram_line_ctrl_chk.sv
// Protocol checker for sdram_line_ctrl, attached by bind.
// Watches only the top-level ports.
module sdram_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_ack,
    input logic       sd_ras_n,
    input logic       sd_cas_n,
    input logic       sd_we_n,
    input logic [3:0] sd_dqm,
    input logic       sd_dq_oe
);
    logic [2:0] c;
    assign c = {sd_ras_n, sd_cas_n, sd_we_n};

    assert_wdata_only_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (xfer_ack && c == 3'b100));

    assert_read_cmd_before_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !sd_dq_oe) |-> ($past(c) == 3'b101));

    assert_act_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'b011) |-> ($past(c, 2) == 3'b010));

    assert_refresh_after_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 3'b001) |-> ($past(c) == 3'b010));

    assert_no_row_cmd_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> (c != 3'b011 && c != 3'b010));

    assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> ($countones(~sd_dqm) == 1 || $countones(~sd_dqm) == 2
                      || $countones(~sd_dqm) == 4));
endmodule

bind sdram_line_ctrl sdram_line_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer_ack(xfer_ack),
    .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n),
    .sd_we_n (sd_we_n),
    .sd_dqm  (sd_dqm),
    .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_line_ctrl_test.sv
// Self-checking bench for sdram_line_ctrl with an inline SDRAM responder.
module sdram_line_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PER    = 1500;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, burst = 1'b0, rd_nwr = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [31:0] addr = '0, wdata = '0, rdata, sd_dq_o;
    logic [31:0] sd_dq_i = '0;
    logic        xfer_ack, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [11:0] sd_addr;
    logic [3:0]  sd_dqm;
    logic [11:0] model_row = '0;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_line_ctrl #(.REF_PERIOD(REF_PER)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .burst(burst),
        .rd_nwr(rd_nwr), .size(size), .addr(addr), .wdata(wdata), .rdata(rdata),
        .xfer_ack(xfer_ack), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o),
        .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    function automatic logic [31:0] pat(logic [11:0] r, logic [7:0] c);
        return {8'hA5, 4'h0, r, c};
    endfunction

    // Behavioural SDRAM: remembers the activated row, returns a pattern a cycle after READ
    always @(posedge clk) begin
        if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b011) model_row <= sd_addr;
        if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b101) sd_dq_i <= pat(model_row, sd_addr[7:0]);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {rd, burst, size, addr, latency, dqm}
    localparam logic [43:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 2'b00, 32'h0000_1440, 4'd7, 4'h0},  // first access after reset: miss (R8)
        {1'b1, 1'b1, 2'b00, 32'h0000_144C, 4'd5, 4'h0},  // read hit, wraps 3,0,1,2
        {1'b0, 1'b1, 2'b00, 32'h0000_1488, 4'd3, 4'h0},  // write hit
        {1'b1, 1'b1, 2'b00, 32'h0000_2414, 4'd9, 4'h0},  // read miss
        {1'b0, 1'b0, 2'b01, 32'h0000_24C1, 4'd3, 4'hB},  // byte write, lane 2
        {1'b1, 1'b0, 2'b10, 32'h0000_24C6, 4'd5, 4'hC},  // word read, lanes 1,0
        {1'b0, 1'b0, 2'b00, 32'h0000_0820, 4'd7, 4'h0},  // long write miss
        {1'b1, 1'b0, 2'b01, 32'h0000_0827, 4'd5, 4'hE},  // byte read, lane 0
        {1'b0, 1'b0, 2'b10, 32'h0000_0828, 4'd3, 4'h3},  // word write, lanes 3,2
        {1'b1, 1'b1, 2'b00, 32'h0000_0904, 4'd5, 4'h0}   // read hit, start col low 1
    };

    task automatic run_txn(input logic rd, input logic bst, input logic [1:0] sz,
                           input logic [31:0] ad, input int lat, input logic [3:0] dqm_exp,
                           input bit chk_lat, output int got_lat);
        int c = 1, acts = 0;
        string lreq;
        logic [7:0] col;
        @(negedge clk);
        rd_nwr = rd; burst = bst; size = sz; addr = ad; xfer_start = 1'b1;
        wdata = 32'hC0DE_0000 ^ ad;
        chk(xfer_ack == 1'b0, "R5", {31'd0, xfer_ack}, 32'd0);
        do begin
            @(negedge clk);
            c++;
            xfer_start = 1'b0;
            if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b011 && !xfer_ack) acts++;
        end while (!xfer_ack && c < 20);
        got_lat = c;
        lreq = rd ? (lat > 5 ? "R4" : "R2") : (lat > 3 ? "R3" : "R1");
        if (chk_lat) chk(c == lat, lreq, c, lat);
        chk(acts == (lat > 5 ? 1 : 0), "R8", acts, (lat > 5 ? 1 : 0));
        for (int b = 0; b < (bst ? 4 : 1); b++) begin
            col = {ad[9:4], ad[3:2] + 2'(b)};
            chk(xfer_ack == 1'b1, "R5", {31'd0, xfer_ack}, 32'd1);
            chk(sd_dqm == dqm_exp, "R7", {28'd0, sd_dqm}, {28'd0, dqm_exp});
            if (rd) begin
                chk(rdata == pat(ad[21:10], col), "R6", rdata, pat(ad[21:10], col));
            end else begin
                chk(sd_dq_oe && sd_dq_o == wdata, "R6", sd_dq_o, wdata);
                chk(sd_addr[7:0] == col, "R6", {24'd0, sd_addr[7:0]}, {24'd0, col});
                wdata = wdata + 32'd1;
            end
            @(negedge clk);
        end
        chk(xfer_ack == 1'b0, "R5", {31'd0, xfer_ack}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int got, acks;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(xfer_ack == 1'b0, "R8", {31'd0, xfer_ack}, 32'd0);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R8", {29'd0, sd_ras_n, sd_cas_n, sd_we_n}, 32'd7);
        chk(sd_dq_oe == 1'b0, "R8", {31'd0, sd_dq_oe}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            v = VECS[i];
            run_txn(v[43], v[42], v[41:40], v[39:8], int'(v[7:4]), v[3:0], 1'b1, got);
        end

        // R10: strobe during a read-hit burst is ignored
        @(negedge clk);
        rd_nwr = 1'b1; burst = 1'b1; size = 2'b00; addr = 32'h0000_0900; xfer_start = 1'b1;
        acks = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            xfer_start = (k == 1 || k == 4);
            if (xfer_ack) acks++;
        end
        xfer_start = 1'b0;
        chk(acks == 4, "R10", acks, 4);

        // R9: after the refresh command the open row is closed
        got = 0;
        for (int k = 0; k < 3000 && got == 0; k++) begin
            @(negedge clk);
            if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001) got = 1;
        end
        chk(got == 1, "R9", got, 1);
        repeat (10) @(negedge clk);
        run_txn(1'b1, 1'b1, 2'b00, 32'h0000_0904, 9, 4'h0, 1'b0, got);
        chk(got == 9, "R9", got, 9);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule